// File: doc/BRIEF.md
# Lane Reduce and Prefix-Sum Engine

The engine takes one value from each of 32 lanes (signed 32-bit integers) and either folds them to a single sum, maximum or minimum, or turns them into running totals. It imitates a register-exchange network: in each clock cycle every lane reads one other lane's value at a power-of-two distance and merges it with its own. A fold uses distances that halve at each step, so lane 0 of a group ends up holding the group's result. A final cycle then copies that result to every lane of the group. A running total uses distances that double at each step, and a lane only adds the value it reads when its position in the group is at least the distance.

Lanes can be split into aligned groups (tiles) of 2, 4, 8, 16 or 32 lanes. Each tile is processed on its own, in log2(tile width) exchange steps. A lane-active mask turns off chosen lanes. An inactive lane adds nothing to the result: it carries the neutral value of the chosen operation. A single start pulse launches one operation. The inputs are captured at that edge, and a one-cycle done pulse marks when the result is ready.

Top module: `lane_reduce_scan`

## Requirements
- R1: With op = 0 (sum), every lane of a tile returns the sum of the tile's active inputs, wrapping modulo 2^32 with no saturation.
- R2: With op = 1 (max), every lane of a tile returns the largest active input of the tile, compared as signed values.
- R3: With op = 2 (min), every lane of a tile returns the smallest active input of the tile, compared as signed values.
- R4: A lane whose lane_active bit is 0 behaves as if its input were the operation's neutral value: 0 for sum and prefix sum, 0x80000000 for max, 0x7FFFFFFF for min. A tile with no active lane therefore returns that neutral value.
- R5: With op = 3 (inclusive prefix sum), lane i returns the wrapped sum of the active inputs of the lanes from the first lane of its tile up to and including lane i.
- R6: width_code w selects tiles of 2^w consecutive lanes that are aligned to multiples of 2^w. Code 0 is treated as 1 and codes 6 and 7 are treated as 5. An operation takes exactly w exchange steps.
- R7: If start is sampled high at clock edge E0, done is high for exactly one cycle: after edge E(w) for a prefix sum, and after edge E(w+1) for sum, max or min (the extra edge is the broadcast).
- R8: A start pulse that arrives while an operation is in progress is ignored. op, lane_active, width_code and lane_in are taken only at the accepted start edge.
- R9: After reset, result is all zero and done is low. result keeps its value from the done pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch strobe, sampled while idle |
| op | input | 2 | 0 sum, 1 max, 2 min, 3 inclusive prefix sum |
| lane_active | input | 32 | Bit i enables lane i |
| width_code | input | 3 | log2 of the tile width |
| lane_in | input | 1024 | Lane i value in bits [32i+31:32i] |
| result | output | 1024 | Lane i result in bits [32i+31:32i] |
| done | output | 1 | One-cycle pulse when result is valid |

## Verification
The assertions assume that start, op, width_code and lane_active are settled at every sampled edge. The bench meets this by changing inputs only on the falling clock edge. The assertions also assume that an out-of-range width code has already been clamped. The sequencer does this clamp itself, so the bench deliberately drives codes 0 and 7. A start that arrives while the engine is busy is the only input pattern that must leave no trace. The bench drives one with a different operation and different data, then checks both the result and the done timing of the first operation.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [1:0] {
    OPC_SUM  = 2'd0,
    OPC_MAX  = 2'd1,
    OPC_MIN  = 2'd2,
    OPC_SCAN = 2'd3
  } lrs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP  = 2'd1,
    ST_BCAST = 2'd2
  } lrs_state_e;

endpackage

// File: rtl/lrs_combine.sv
module lrs_combine
  import lrs_pkg::*;
#(
  parameter int DW = 32
) (
  input  lrs_op_e       op_i,
  input  logic [DW-1:0] own_i,
  input  logic [DW-1:0] peer_i,
  output logic [DW-1:0] merged_o
);

  logic own_gt;

  assign own_gt = $signed(own_i) > $signed(peer_i);

  always_comb begin
    unique case (op_i)
      OPC_MAX: merged_o = own_gt ? own_i : peer_i;
      OPC_MIN: merged_o = own_gt ? peer_i : own_i;
      default: merged_o = own_i + peer_i;
    endcase
  end

endmodule

// File: rtl/lrs_shuffle_net.sv
module lrs_shuffle_net
  import lrs_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES-1:0][DW-1:0] vals_i,
  input  lrs_op_e                  op_i,
  input  logic [LW-1:0]            wmask_i,
  input  logic [LW-1:0]            offset_i,
  input  logic                     bcast_i,
  output logic [LANES-1:0][DW-1:0] vals_o
);

  logic is_scan;
  assign is_scan = (op_i == OPC_SCAN);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LW-1:0] IDX = LW'(g);

    logic [LW-1:0] pos;
    logic [LW:0]   reach;
    logic          dn_ok, up_ok, use_peer;
    logic [LW-1:0] src;
    logic [DW-1:0] peer, merged, leader;

    assign pos      = IDX & wmask_i;
    assign reach    = {1'b0, pos} + {1'b0, offset_i};
    assign dn_ok    = reach <= {1'b0, wmask_i};
    assign up_ok    = pos >= offset_i;
    assign use_peer = is_scan ? up_ok : dn_ok;
    assign src      = is_scan ? (IDX - offset_i) : (IDX + offset_i);
    assign peer     = vals_i[src];
    assign leader   = vals_i[IDX & ~wmask_i];

    lrs_combine #(.DW(DW)) u_comb (
      .op_i    (op_i),
      .own_i   (vals_i[g]),
      .peer_i  (peer),
      .merged_o(merged)
    );

    always_comb begin
      if (bcast_i)       vals_o[g] = leader;
      else if (use_peer) vals_o[g] = merged;
      else               vals_o[g] = vals_i[g];
    end
  end

endmodule

// File: rtl/lrs_sequencer.sv
module lrs_sequencer
  import lrs_pkg::*;
#(
  parameter int LANES = 32,
  localparam int LW   = $clog2(LANES),
  localparam int WCW  = $clog2(LW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     op_i,
  input  logic [WCW-1:0] wcode_i,
  output logic           busy_o,
  output logic           load_o,
  output logic           step_en_o,
  output logic           bcast_o,
  output logic           done_o,
  output lrs_op_e        op_o,
  output logic [LW-1:0]  wmask_o,
  output logic [LW-1:0]  offset_o
);

  lrs_state_e     state_q, state_d;
  logic [WCW-1:0] step_q, step_d;
  logic [WCW-1:0] nsteps_q, nsteps_d;
  lrs_op_e        op_q, op_d;
  logic           done_q, done_d;
  logic [WCW-1:0] wclamp, shamt;
  logic           last_step;

  always_comb begin
    if (wcode_i == '0)            wclamp = WCW'(1);
    else if (wcode_i > WCW'(LW))  wclamp = WCW'(LW);
    else                          wclamp = wcode_i;
  end

  assign last_step = (step_q == nsteps_q - WCW'(1));

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    nsteps_d  = nsteps_q;
    op_d      = op_q;
    done_d    = 1'b0;
    load_o    = 1'b0;
    step_en_o = 1'b0;
    bcast_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o   = 1'b1;
          state_d  = ST_STEP;
          step_d   = '0;
          nsteps_d = wclamp;
          op_d     = lrs_op_e'(op_i);
        end
      end
      ST_STEP: begin
        step_en_o = 1'b1;
        if (last_step) begin
          if (op_q == OPC_SCAN) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_BCAST;
          end
        end else begin
          step_d = step_q + WCW'(1);
        end
      end
      ST_BCAST: begin
        bcast_o = 1'b1;
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      nsteps_q <= WCW'(1);
      op_q     <= OPC_SUM;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      nsteps_q <= nsteps_d;
      op_q     <= op_d;
      done_q   <= done_d;
    end
  end

  assign shamt    = (op_q == OPC_SCAN) ? step_q : (nsteps_q - WCW'(1) - step_q);
  assign offset_o = {{(LW-1){1'b0}}, 1'b1} << shamt;
  assign wmask_o  = ~({LW{1'b1}} << nsteps_q);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign op_o     = op_q;

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP) |-> (step_q < nsteps_q)); // R6
  AST_NSTEPS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (nsteps_q >= WCW'(1) && nsteps_q <= WCW'(LW))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP && start_i) |=>
      ($stable(op_q) && (state_q != ST_STEP || step_q == $past(step_q) + WCW'(1)))); // R8

endmodule

// File: rtl/lane_reduce_scan.sv
module lane_reduce_scan
  import lrs_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int LW   = $clog2(LANES),
  localparam int WCW  = $clog2(LW + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            op,
  input  logic [LANES-1:0]      lane_active,
  input  logic [WCW-1:0]        width_code,
  input  logic [LANES*DW-1:0]   lane_in,
  output logic [LANES*DW-1:0]   result,
  output logic                  done
);

  logic                     busy, load, step_en, bcast;
  lrs_op_e                  op_run, op_new;
  logic [LW-1:0]            wmask, offset;
  logic [LANES-1:0][DW-1:0] vals_q, vals_d, net_out, loaded;
  logic [DW-1:0]            neutral;
  logic                     vals_en;

  lrs_sequencer #(.LANES(LANES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .op_i     (op),
    .wcode_i  (width_code),
    .busy_o   (busy),
    .load_o   (load),
    .step_en_o(step_en),
    .bcast_o  (bcast),
    .done_o   (done),
    .op_o     (op_run),
    .wmask_o  (wmask),
    .offset_o (offset)
  );

  lrs_shuffle_net #(.LANES(LANES), .DW(DW)) u_net (
    .vals_i  (vals_q),
    .op_i    (op_run),
    .wmask_i (wmask),
    .offset_i(offset),
    .bcast_i (bcast),
    .vals_o  (net_out)
  );

  assign op_new = lrs_op_e'(op);

  always_comb begin
    unique case (op_new)
      OPC_MAX: neutral = {1'b1, {(DW-1){1'b0}}};
      OPC_MIN: neutral = {1'b0, {(DW-1){1'b1}}};
      default: neutral = '0;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_load
    assign loaded[g] = lane_active[g] ? lane_in[g*DW +: DW] : neutral;
    assign result[g*DW +: DW] = vals_q[g];
  end

  assign vals_en = load | step_en | bcast;
  assign vals_d  = load ? loaded : net_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vals_q <= '0;
    else if (vals_en) vals_q <= vals_d;
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(vals_q)); // R9

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    localparam logic [LW-1:0] IDX = LW'(g);
    AST_BCAST_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_run != OPC_SCAN) |-> (vals_q[g] == vals_q[IDX & ~wmask])); // R1
  end

endmodule

// File: tb/lane_reduce_scan_bench.sv
`timescale 1ns/1ps
module lane_reduce_scan_bench;

  localparam int  N   = 32;
  localparam time TCK = 4ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    op;
  logic [N-1:0]  lane_active;
  logic [2:0]    width_code;
  logic [N*32-1:0] lane_in, result;
  logic          done;

  int checks = 0;
  int fails  = 0;

  logic [31:0] vin  [N];
  logic [31:0] vexp [N];
  logic [31:0] vsave[N];

  always #(TCK/2) clk = ~clk;

  lane_reduce_scan u_lane_reduce_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .lane_active(lane_active), .width_code(width_code),
    .lane_in(lane_in), .result(result), .done(done)
  );

  // {op[70:69], wcode[68:66], active[65:34], pattern[33:32], seed[31:0]}
  localparam int NV = 12;
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 3'd5, 32'hFFFF_FFFF, 2'd2, 32'h1357_9BDF},  // R1 sum, full warp
    {2'd1, 3'd5, 32'h0F0F_F0F0, 2'd2, 32'h2468_ACE0},  // R2 max, sparse lanes
    {2'd2, 3'd5, 32'hFFFF_0001, 2'd0, 32'h0000_0000},  // R3 min
    {2'd3, 3'd5, 32'hFFFF_FFFF, 2'd0, 32'h0000_0000},  // R5 scan
    {2'd0, 3'd4, 32'hFFFF_FFFF, 2'd1, 32'h0000_0000},  // R1 wrap, 16-lane tiles
    {2'd3, 3'd3, 32'hAAAA_AAAA, 2'd2, 32'hDEAD_BEEF},  // R5 R4 scan, 8-lane tiles
    {2'd1, 3'd1, 32'hFFFF_FFFF, 2'd0, 32'h0000_0000},  // R2 R6 pairs
    {2'd2, 3'd2, 32'h1234_5678, 2'd2, 32'h0BAD_F00D},  // R3 R6 quads
    {2'd0, 3'd0, 32'hFFFF_FFFF, 2'd0, 32'h0000_0000},  // R6 code 0 -> pairs
    {2'd3, 3'd7, 32'hFFFF_FFFF, 2'd1, 32'h0000_0000},  // R6 code 7 -> 32
    {2'd1, 3'd5, 32'h0000_0000, 2'd2, 32'h5555_0000},  // R4 max neutral
    {2'd2, 3'd5, 32'h0000_0000, 2'd2, 32'h5555_0000}   // R4 min neutral
  };

  function automatic logic [31:0] pat(input logic [1:0] sel, input logic [31:0] seed, input int lane);
    case (sel)
      2'd0:    return 32'(lane * 3) - 32'd40;
      2'd1:    return 32'h7FFF_FFF0 + 32'(lane);
      default: return (32'(lane + 1) * 32'h9E37_79B1) ^ seed;
    endcase
  endfunction

  function automatic int eff_w(input logic [2:0] wc);
    if (wc == 0) return 1;
    if (wc > 5)  return 5;
    return int'(wc);
  endfunction

  task automatic reference(input logic [1:0] o, input logic [2:0] wc, input logic [N-1:0] act);
    int w = 1 << eff_w(wc);
    for (int base = 0; base < N; base += w) begin
      logic [31:0] acc;
      acc = (o == 2'd1) ? 32'h8000_0000 : (o == 2'd2) ? 32'h7FFF_FFFF : 32'h0;
      for (int k = base; k < base + w; k++) begin
        if (act[k]) begin
          case (o)
            2'd1:    if ($signed(vin[k]) > $signed(acc)) acc = vin[k];
            2'd2:    if ($signed(vin[k]) < $signed(acc)) acc = vin[k];
            default: acc = acc + vin[k];
          endcase
        end
        if (o == 2'd3) vexp[k] = acc;
      end
      if (o != 2'd3) for (int k = base; k < base + w; k++) vexp[k] = acc;
    end
  endtask

  task automatic drive(input logic [1:0] o, input logic [2:0] wc, input logic [N-1:0] act);
    op = o; width_code = wc; lane_active = act;
    for (int k = 0; k < N; k++) lane_in[k*32 +: 32] = vin[k];
  endtask

  task automatic check_lanes(input string req, input string tag);
    int bad = -1;
    checks++;
    for (int k = 0; k < N; k++)
      if (bad < 0 && result[k*32 +: 32] !== vexp[k]) bad = k;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s %s lane %0d actual %h expected %h", req, tag, bad,
               result[bad*32 +: 32], vexp[bad]);
    end
  endtask

  task automatic check_val(input string req, input int act_v, input int exp_v, input string tag);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, tag, act_v, exp_v);
    end
  endtask

  // waits for done, starting from a count of cycles already elapsed since E0
  task automatic await_done(input int already, input int lat, input string tag);
    int cnt = already;
    do begin
      @(negedge clk);
      cnt++;
    end while (!done && cnt < 40);
    check_val("R7", cnt, lat, {tag, " latency"});
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(TCK * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; width_code = 3'd5;
    lane_active = '0; lane_in = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int k = 0; k < N; k++) vexp[k] = '0;
    check_lanes("R9", "reset result");
    check_val("R9", int'(done), 0, "reset done");
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [70:0] e = VEC[v];
      int lat;
      for (int k = 0; k < N; k++) vin[k] = pat(e[33:32], e[31:0], k);
      reference(e[70:69], e[68:66], e[65:34]);
      drive(e[70:69], e[68:66], e[65:34]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = eff_w(e[68:66]) + ((e[70:69] == 2'd3) ? 0 : 1);
      await_done(0, lat, $sformatf("vec%0d", v));
      check_lanes(e[70:69] == 2'd0 ? "R1" : e[70:69] == 2'd1 ? "R2" :
                  e[70:69] == 2'd2 ? "R3" : "R5", $sformatf("vec%0d", v));
      @(negedge clk);
      check_val("R7", int'(done), 0, $sformatf("vec%0d done single", v));
    end

    // R8: start during a busy sum is ignored
    for (int k = 0; k < N; k++) vin[k] = pat(2'd2, 32'hCAFE_0001, k);
    reference(2'd0, 3'd5, '1);
    drive(2'd0, 3'd5, '1);
    start = 1'b1;
    @(negedge clk);
    for (int k = 0; k < N; k++) vsave[k] = vexp[k];
    for (int k = 0; k < N; k++) vin[k] = 32'(k);
    drive(2'd3, 3'd1, 32'h0000_FFFF);
    @(negedge clk);
    start = 1'b0;
    await_done(1, 6, "R8 busy start");
    for (int k = 0; k < N; k++) vexp[k] = vsave[k];
    check_lanes("R8", "busy start result");

    // R9: result holds while idle with new inputs and no start
    repeat (4) @(negedge clk);
    check_lanes("R9", "hold after done");
    check_val("R9", int'(done), 0, "no done while idle");

    summary();
  end

endmodule